// File: doc/BRIEF.md
# Dual Event Counter

This block holds two free-running up-counters, B and C, that share one byte-wide control register. Each counter can be switched on or off, told to count either the instruction-cycle strobe or transitions on its own external count pin, and told whether a rising or a falling pin transition is the one that counts. Counter C is always one byte wide. Counter B is one byte wide by default and can bring in a second byte at run time to become a 16-bit counter.

Software uses a small register port to reach the block. It writes the control byte, loads or reads the counter bytes, and watches two sticky wrap flags. Each flag is set when its counter rolls over from all ones to zero, and it is cleared by writing a one to it. Each counter also has an output that tells the pin logic whether its count pin is left free for general I/O. That is the case whenever the counter is not taking its events from the pin.

Top module: `dual_event_counter`

## Requirements
- R1: After reset, the control byte, both counters and both wrap flags read as zero, and both pin-free outputs are high.
- R2: The control byte at address 0 holds, from bit 7 down to bit 0: B wide mode, B enable, B source, B edge, a reserved bit, C enable, C source, C edge. The reserved bit 3 always reads 0.
- R3: When a counter's source bit is 0 and the counter is enabled, it adds one for each clock cycle in which `cyc_stb` is high, and its pin-free output is high. When the source bit is 1, the strobe has no effect and the pin-free output is low.
- R4: When a counter's source bit is 1, a pin transition is synchronized by two flops and then edge-detected. If the edge bit is 0, a rising transition counts. If the edge bit is 1, a falling transition counts. The new count is visible after the third rising clock edge that follows the pin change.
- R5: A counter whose enable bit is 0 holds its value, whatever happens on the strobe and on the pins.
- R6: While B wide mode is 0, the B high byte (address 2) reads 0 and ignores writes. B wraps from 255 to 0 and sets its flag, which is flag bit 0 at address 4.
- R7: While B wide mode is 1, a carry out of the B low byte (address 1) increments the high byte. B wraps from 65535 to 0 and sets flag bit 0.
- R8: Counter C (address 3) wraps from 255 to 0 and sets its flag, which is flag bit 1 at address 4.
- R9: Each wrap flag stays set until a 1 is written to its bit at address 4. Writing 0 to a flag bit leaves it unchanged. The flags also appear on `ovf_b` and `ovf_c`.
- R10: A register write to a counter byte in the same cycle as a count event loads the written value, and the count event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 B low, 2 B high, 3 C, 4 flags |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational read data for `reg_addr` |
| cyc_stb | input | 1 | Instruction-cycle strobe, one cycle per tick |
| pin_b | input | 1 | External count pin of counter B (asynchronous) |
| pin_c | input | 1 | External count pin of counter C (asynchronous) |
| ovf_b | output | 1 | Sticky wrap flag of counter B |
| ovf_c | output | 1 | Sticky wrap flag of counter C |
| gpio_free_b | output | 1 | High when pin B is left for general I/O |
| gpio_free_c | output | 1 | High when pin C is left for general I/O |

## Verification
A counter-byte load and a counting strobe can land in the same clock cycle. The bench provokes this by raising `cyc_stb` in the cycle in which it writes counter C. It then reads C back and expects exactly the written value, not that value plus one. A second strobe after the write must then add exactly one. This shows that the dropped event was dropped once and did not stick.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic b_wide;
      logic b_en;
      logic b_src;
      logic b_fall;
      logic rsvd;
      logic c_en;
      logic c_src;
      logic c_fall;
   } ctrl_t;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_BLO  = 3'd1;
   localparam logic [2:0] A_BHI  = 3'd2;
   localparam logic [2:0] A_C    = 3'd3;
   localparam logic [2:0] A_FLAG = 3'd4;
endpackage

// File: rtl/evcnt_edge_sync.sv
module evcnt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad
      $error("evcnt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~prev_q;
   assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
   parameter bit  HAS_WIDE = 1'b0,
   localparam int LO_W     = evcnt_pkg::BYTE_W,
   localparam int WIDTH    = HAS_WIDE ? 2 * LO_W : LO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             src_pin,
   input  logic             edge_fall,
   input  logic             wide,
   input  logic             tick,
   input  logic             rise,
   input  logic             fall,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [LO_W-1:0]  wr_data,
   input  logic             ovf_clr,
   output logic [WIDTH-1:0] value,
   output logic             ovf
);
   logic [LO_W-1:0] lo_q;
   logic            wide_eff;
   logic            any_wr;
   logic            evt;
   logic            step;
   logic            wrap;

   assign evt    = en & (src_pin ? (edge_fall ? fall : rise) : tick);
   assign any_wr = wr_lo | (wr_hi & wide_eff);
   assign step   = evt & ~any_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (wr_lo) lo_q <= wr_data;
      else if (step)  lo_q <= lo_q + 1'b1;
   end

   if (HAS_WIDE) begin : g_wide
      logic [LO_W-1:0] hi_q;
      assign wide_eff = wide;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                hi_q <= '0;
         else if (!wide)            hi_q <= '0;
         else if (wr_hi)            hi_q <= wr_data;
         else if (step && (&lo_q))  hi_q <= hi_q + 1'b1;
      end

      assign wrap  = wide ? ((&lo_q) & (&hi_q)) : (&lo_q);
      assign value = {hi_q, lo_q};
   end else begin : g_narrow
      assign wide_eff = 1'b0;
      assign wrap     = &lo_q;
      assign value    = lo_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf <= 1'b0;
      else if (step && wrap)   ovf <= 1'b1;
      else if (ovf_clr)        ovf <= 1'b0;
   end
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3,
   localparam int DW         = evcnt_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     rd_data,
   input  logic              cyc_stb,
   input  logic              pin_b,
   input  logic              pin_c,
   output logic              ovf_b,
   output logic              ovf_c,
   output logic              gpio_free_b,
   output logic              gpio_free_c
);
   import evcnt_pkg::*;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("dual_event_counter: ADDR_W must be at least 3");
   end

   ctrl_t            ctrl_q;
   logic [2*DW-1:0]  cnt_b;
   logic [DW-1:0]    cnt_c;
   logic             rise_b, fall_b, rise_c, fall_c;
   logic             sel_ctrl, sel_blo, sel_bhi, sel_c, sel_flag;

   assign sel_ctrl = wr_en && (reg_addr == ADDR_W'(A_CTRL));
   assign sel_blo  = wr_en && (reg_addr == ADDR_W'(A_BLO));
   assign sel_bhi  = wr_en && (reg_addr == ADDR_W'(A_BHI));
   assign sel_c    = wr_en && (reg_addr == ADDR_W'(A_C));
   assign sel_flag = wr_en && (reg_addr == ADDR_W'(A_FLAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (sel_ctrl) begin
         ctrl_q      <= ctrl_t'(wr_data);
         ctrl_q.rsvd <= 1'b0;
      end
   end

   evcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .pin(pin_b), .rise(rise_b), .fall(fall_b)
   );

   evcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_c (
      .clk(clk), .rst_n(rst_n), .pin(pin_c), .rise(rise_c), .fall(fall_c)
   );

   evcnt_counter #(.HAS_WIDE(1'b1)) u_cnt_b (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.b_en), .src_pin(ctrl_q.b_src), .edge_fall(ctrl_q.b_fall),
      .wide(ctrl_q.b_wide), .tick(cyc_stb), .rise(rise_b), .fall(fall_b),
      .wr_lo(sel_blo), .wr_hi(sel_bhi), .wr_data(wr_data),
      .ovf_clr(sel_flag && wr_data[0]), .value(cnt_b), .ovf(ovf_b)
   );

   evcnt_counter #(.HAS_WIDE(1'b0)) u_cnt_c (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.c_en), .src_pin(ctrl_q.c_src), .edge_fall(ctrl_q.c_fall),
      .wide(1'b0), .tick(cyc_stb), .rise(rise_c), .fall(fall_c),
      .wr_lo(sel_c), .wr_hi(1'b0), .wr_data(wr_data),
      .ovf_clr(sel_flag && wr_data[1]), .value(cnt_c), .ovf(ovf_c)
   );

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(A_CTRL): rd_data = ctrl_q;
         ADDR_W'(A_BLO):  rd_data = cnt_b[DW-1:0];
         ADDR_W'(A_BHI):  rd_data = cnt_b[2*DW-1:DW];
         ADDR_W'(A_C):    rd_data = cnt_c;
         ADDR_W'(A_FLAG): rd_data = {{(DW-2){1'b0}}, ovf_c, ovf_b};
         default:         rd_data = '0;
      endcase
   end

   assign gpio_free_b = ~ctrl_q.b_src;
   assign gpio_free_c = ~ctrl_q.c_src;
endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [2:0]  reg_addr,
   input logic [7:0]  wr_data,
   input logic [7:0]  rd_data,
   input logic [7:0]  ctrl_q,
   input logic [15:0] cnt_b,
   input logic [7:0]  cnt_c,
   input logic        ovf_c
);
   // R2
   ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> (rd_data[3] == 1'b0));

   // R5
   c_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[2] && !(wr_en && reg_addr == 3'd3)) |=> $stable(cnt_c));

   // R6
   b_narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[7] |=> (cnt_b[15:8] == 8'h00));

   // R9
   c_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_c && !(wr_en && reg_addr == 3'd4 && wr_data[1])) |=> ovf_c);

   // R8
   c_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en && reg_addr == 3'd3) && (cnt_c != $past(cnt_c)))
         |-> (cnt_c == 8'($past(cnt_c) + 8'd1)));
endmodule

bind dual_event_counter evcnt_chk u_evcnt_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
   .wr_data(wr_data), .rd_data(rd_data), .ctrl_q(ctrl_q),
   .cnt_b(cnt_b), .cnt_c(cnt_c), .ovf_c(ovf_c)
);

// File: tb/tb_dual_event_counter.sv
module tb_dual_event_counter;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 5;
   // each entry: {ctrl, preload, strobes, expected C, expected C flag}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'h04, 8'd10,  8'd5, 8'd15, 8'd0},
      {8'h04, 8'd254, 8'd3, 8'd1,  8'd1},
      {8'h00, 8'd7,   8'd4, 8'd7,  8'd0},
      {8'h06, 8'd20,  8'd4, 8'd20, 8'd0},
      {8'h04, 8'd255, 8'd1, 8'd0,  8'd1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       cyc_stb = 1'b0;
   logic       pin_b = 1'b0;
   logic       pin_c = 1'b0;
   logic       ovf_b, ovf_c, gpio_free_b, gpio_free_c;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_event_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .cyc_stb(cyc_stb),
      .pin_b(pin_b), .pin_c(pin_c), .ovf_b(ovf_b), .ovf_c(ovf_c),
      .gpio_free_b(gpio_free_b), .gpio_free_c(gpio_free_c)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cyc_stb = 1'b1;
         @(negedge clk); cyc_stb = 1'b0;
      end
   endtask

   task automatic wait_sync();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 reg after reset", d, 0);
      end
      check("R1 pin-free B", gpio_free_b, 1);
      check("R1 pin-free C", gpio_free_c, 1);

      // R2 control layout, reserved bit reads zero
      wr(3'd0, 8'hFF);
      rd(3'd0, d);
      check("R2 ctrl readback", d, 8'hF7);
      check("R3 pin-free B low on pin source", gpio_free_b, 0);
      check("R3 pin-free C low on pin source", gpio_free_c, 0);

      // Vector table on counter C (R3, R5, R8)
      for (int v = 0; v < NVEC; v++) begin
         wr(3'd0, VEC[v][39:32]);
         wr(3'd4, 8'h03);
         wr(3'd3, VEC[v][31:24]);
         pulse(int'(VEC[v][23:16]));
         rd(3'd3, d);
         check("R3/R5/R8 vector count", d, VEC[v][15:8]);
         rd(3'd4, d);
         check("R8 vector flag", d[1], VEC[v][0]);
      end

      // R9 writing 0 keeps flag, writing 1 clears it
      wr(3'd4, 8'h00);
      check("R9 flag kept", ovf_c, 1);
      wr(3'd4, 8'h02);
      check("R9 flag cleared", ovf_c, 0);

      // R10 write versus strobe in the same cycle
      wr(3'd0, 8'h04);
      @(negedge clk);
      wr_en = 1'b1; reg_addr = 3'd3; wr_data = 8'h40; cyc_stb = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; cyc_stb = 1'b0;
      rd(3'd3, d);
      check("R10 write wins", d, 8'h40);
      pulse(1);
      rd(3'd3, d);
      check("R10 next strobe counts once", d, 8'h41);

      // R6 narrow B: high byte ignores writes, wraps at 255
      wr(3'd0, 8'h40);
      wr(3'd2, 8'h55);
      rd(3'd2, d);
      check("R6 high byte zero", d, 0);
      wr(3'd1, 8'hFF);
      pulse(1);
      rd(3'd1, d);
      check("R6 narrow wrap", d, 0);
      check("R6 B flag", ovf_b, 1);
      wr(3'd4, 8'h01);

      // R7 wide B: carry and full wrap
      wr(3'd0, 8'hC0);
      wr(3'd2, 8'h12);
      wr(3'd1, 8'hFF);
      pulse(1);
      rd(3'd2, d);
      check("R7 carry into high", d, 8'h13);
      check("R7 no flag on carry", ovf_b, 0);
      wr(3'd2, 8'hFF);
      wr(3'd1, 8'hFF);
      pulse(1);
      rd(3'd2, d);
      check("R7 full wrap high", d, 0);
      check("R7 full wrap flag", ovf_b, 1);

      // R4 pin source, falling edge on B
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h70);
      wr(3'd1, 8'h00);
      @(negedge clk); pin_b = 1'b1;
      wait_sync();
      rd(3'd1, d);
      check("R4 B rise ignored on fall edge", d, 0);
      @(negedge clk); pin_b = 1'b0;
      wait_sync();
      rd(3'd1, d);
      check("R4 B falling counted", d, 1);

      // R4 pin source, rising edge on C
      wr(3'd0, 8'h06);
      wr(3'd3, 8'h00);
      @(negedge clk); pin_c = 1'b1;
      wait_sync();
      rd(3'd3, d);
      check("R4 C rising counted", d, 1);
      @(negedge clk); pin_c = 1'b0;
      wait_sync();
      rd(3'd3, d);
      check("R4 C fall ignored", d, 1);

      // R5 disabled pin-sourced counter ignores pin
      wr(3'd0, 8'h02);
      @(negedge clk); pin_c = 1'b1;
      wait_sync();
      rd(3'd3, d);
      check("R5 disabled holds", d, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule